// File: doc/BRIEF.md
# Manchester Line Transmitter with Frame Gating

This block turns 4-bit data nibbles into a Manchester-coded serial line for a 10 Mb/s twisted-pair link. It runs on a single clock at twice the bit rate, so each clock cycle is one half of a bit cell. A frame opens when the transmit enable is seen high while the line is idle. It continues one nibble at a time for as long as the enable is high at each nibble boundary. It closes when the enable is low at a boundary.

Each nibble is shifted out least-significant bit first. The data is carried by the transition in the middle of each cell. Once the last bit has gone out, the line is parked high for a short tail while still driven. As a result, the final transition of a frame lands at the cell boundary when the last bit is a zero, and in the middle of the cell when it is a one. After the tail the driver flag drops and the line rests at its idle level.

Upstream logic uses the nibble request strobe to tell when the next nibble and enable value will be sampled.

Top module: `manch_tx`

## Requirements
- R1: When `tx_en` is high at a rising clock edge while `line_active` is low, `line_active` is high in the very next cycle, and that cycle carries the first half of the first bit.
- R2: Each bit cell lasts two clock cycles. A one is sent as low then high, and a zero as high then low, so every cell has a transition at its middle.
- R3: A nibble on `tx_nib` is captured only at a rising edge where `nib_req` is high. Its bits go out from bit 0 to bit 3. Values on `tx_nib` at any other edge have no effect on the line.
- R4: `tx_en` is sampled only at edges where `nib_req` is high. If it is high at a boundary, the next nibble follows with no gap. Lowering it at other edges has no effect on the frame.
- R5: When `tx_en` is low at a nibble boundary, the line is held high with `line_active` high for exactly TAIL_HALVES cycles (default 4) after the last bit cell.
- R6: A frame whose last bit is zero has its final line transition at the end boundary of that bit cell.
- R7: A frame whose last bit is one has its final line transition at the middle of that bit cell.
- R8: `nib_req` is high in every idle cycle. While sending, it is high only in the second half of the last bit of each nibble, which is the 8th cycle after a nibble is captured.
- R9: After reset, and in the cycle after the tail ends, `line_active` is low and `line_out` is at the idle level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit clock (twice the bit rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable, sampled at nibble boundaries and while idle |
| tx_nib | input | NIB_W | Data nibble, captured when `nib_req` is high |
| nib_req | output | 1 | High in cycles whose closing edge samples `tx_en` and `tx_nib` |
| line_out | output | 1 | Manchester-coded line level |
| line_active | output | 1 | Driver enable, high from the first half-bit through the tail |

## Verification
The bench decodes the line in the middle of each half-bit and scores every decoded bit against a queue of expected bits. A swapped polarity or bit order shows up as miscompared bits, and a missing mid-cell edge shows up as an illegal half pair. Frames end on a zero and on a one, and for each the bench locates the last transition. A design that dropped the high tail, or sized it wrongly, would put that edge on the wrong half-bit or give the wrong tail length. Between boundaries the bench drives junk nibbles and brief drops of the enable. A design that sampled these at the wrong time would corrupt the data or cut the frame short. It also counts the cycles between nibble requests and checks how quickly the line activates.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_TAIL = 2'd2
   } tx_state_e;

endpackage

// File: rtl/mtx_nib_shifter.sv
module mtx_nib_shifter #(
   parameter int NIB_W     = 4,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             shift,
   input  logic [NIB_W-1:0] nib,
   output logic             cur_bit
);

   logic [NIB_W-1:0] sh_q;

   generate
      if (LSB_FIRST) begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sh_q <= '0;
            else if (load)  sh_q <= nib;
            else if (shift) sh_q <= {1'b0, sh_q[NIB_W-1:1]};
         end
         assign cur_bit = sh_q[0];
      end else begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sh_q <= '0;
            else if (load)  sh_q <= nib;
            else if (shift) sh_q <= {sh_q[NIB_W-2:0], 1'b0};
         end
         assign cur_bit = sh_q[NIB_W-1];
      end
   endgenerate

endmodule

// File: rtl/mtx_frame_ctrl.sv
module mtx_frame_ctrl
   import mtx_pkg::*;
#(
   parameter int NIB_W       = 4,
   parameter int TAIL_HALVES = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tx_en,
   output tx_state_e state,
   output logic      phase,
   output logic      load,
   output logic      shift,
   output logic      nib_req
);

   localparam int CNT_W  = (NIB_W > 1) ? $clog2(NIB_W) : 1;
   localparam int TAIL_W = (TAIL_HALVES > 1) ? $clog2(TAIL_HALVES) : 1;
   localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(NIB_W - 1);
   localparam logic [TAIL_W-1:0] LAST_TAIL = TAIL_W'(TAIL_HALVES - 1);

   tx_state_e         state_q;
   logic              phase_q;
   logic [CNT_W-1:0]  bit_cnt_q;
   logic [TAIL_W-1:0] tail_cnt_q;
   logic              at_last_bit;
   logic              boundary;

   assign at_last_bit = (bit_cnt_q == LAST_BIT);
   assign boundary    = (state_q == ST_SEND) && phase_q && at_last_bit;
   assign nib_req     = (state_q == ST_IDLE) || boundary;
   assign load        = nib_req && tx_en;
   assign shift       = (state_q == ST_SEND) && phase_q && !at_last_bit;
   assign state       = state_q;
   assign phase       = phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         phase_q    <= 1'b0;
         bit_cnt_q  <= '0;
         tail_cnt_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (tx_en) begin
                  state_q   <= ST_SEND;
                  phase_q   <= 1'b0;
                  bit_cnt_q <= '0;
               end
            end
            ST_SEND: begin
               phase_q <= ~phase_q;
               if (phase_q) begin
                  if (at_last_bit) begin
                     bit_cnt_q <= '0;
                     if (!tx_en) begin
                        state_q    <= ST_TAIL;
                        tail_cnt_q <= '0;
                     end
                  end else begin
                     bit_cnt_q <= bit_cnt_q + 1'b1;
                  end
               end
            end
            ST_TAIL: begin
               if (tail_cnt_q == LAST_TAIL) state_q <= ST_IDLE;
               else                         tail_cnt_q <= tail_cnt_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R4: an enable seen high at a boundary starts the next nibble at once
   p_continue_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && tx_en) |=> (state_q == ST_SEND && !phase_q && bit_cnt_q == '0));

   // R8: while sending, the request appears only in the second half-bit
   p_req_late_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SEND && nib_req) |-> $past(state_q == ST_SEND && !phase_q));

endmodule

// File: rtl/mtx_line_enc.sv
module mtx_line_enc
   import mtx_pkg::*;
#(
   parameter bit ONE_LOW_FIRST = 1'b1,
   parameter bit IDLE_LVL      = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  tx_state_e state,
   input  logic      phase,
   input  logic      cur_bit,
   output logic      line_out,
   output logic      line_active
);

   logic data_lvl;

   generate
      if (ONE_LOW_FIRST) begin : g_one_low
         assign data_lvl = phase ? cur_bit : ~cur_bit;
      end else begin : g_one_high
         assign data_lvl = phase ? ~cur_bit : cur_bit;
      end
   endgenerate

   always_comb begin
      unique case (state)
         ST_SEND: line_out = data_lvl;
         ST_TAIL: line_out = 1'b1;
         default: line_out = IDLE_LVL;
      endcase
   end

   assign line_active = (state != ST_IDLE);

   // R2: every cell flips the line between its two halves
   p_midcell_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SEND && phase) |-> (line_out != $past(line_out)));

   // R5: the line is high in the last driven cycle of a frame
   p_tail_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_active) |-> $past(line_out) == 1'b1);

endmodule

// File: rtl/manch_tx.sv
module manch_tx
   import mtx_pkg::*;
#(
   parameter int NIB_W         = 4,
   parameter int TAIL_HALVES   = 4,
   parameter bit LSB_FIRST     = 1'b1,
   parameter bit ONE_LOW_FIRST = 1'b1,
   parameter bit IDLE_LVL      = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_en,
   input  logic [NIB_W-1:0] tx_nib,
   output logic             nib_req,
   output logic             line_out,
   output logic             line_active
);

   generate
      if (NIB_W < 2) begin : g_bad_nib
         $error("manch_tx: NIB_W must be at least 2");
      end
      if (TAIL_HALVES < 2 || (TAIL_HALVES % 2) != 0) begin : g_bad_tail
         $error("manch_tx: TAIL_HALVES must be even and at least 2");
      end
   endgenerate

   tx_state_e state;
   logic      phase;
   logic      load;
   logic      shift;
   logic      cur_bit;

   mtx_frame_ctrl #(
      .NIB_W       (NIB_W),
      .TAIL_HALVES (TAIL_HALVES)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .tx_en   (tx_en),
      .state   (state),
      .phase   (phase),
      .load    (load),
      .shift   (shift),
      .nib_req (nib_req)
   );

   mtx_nib_shifter #(
      .NIB_W     (NIB_W),
      .LSB_FIRST (LSB_FIRST)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .shift   (shift),
      .nib     (tx_nib),
      .cur_bit (cur_bit)
   );

   mtx_line_enc #(
      .ONE_LOW_FIRST (ONE_LOW_FIRST),
      .IDLE_LVL      (IDLE_LVL)
   ) u_enc (
      .clk         (clk),
      .rst_n       (rst_n),
      .state       (state),
      .phase       (phase),
      .cur_bit     (cur_bit),
      .line_out    (line_out),
      .line_active (line_active)
   );

   // R1: enable seen while idle opens the frame on the next cycle
   p_start_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_active && tx_en) |=> line_active);

   // R9: the line returns to the idle level when the driver releases it
   p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_active) |-> (line_out == IDLE_LVL));

endmodule

// File: tb/tb_manch_tx.sv
module tb_manch_tx;

   localparam int NIB_W = 4;
   localparam int TAIL  = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tx_en = 1'b0;
   logic [NIB_W-1:0] tx_nib = '0;
   logic             nib_req, line_out, line_active;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   bit exp_q[$];

   always #5 clk = ~clk;

   manch_tx dut (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_nib(tx_nib),
      .nib_req(nib_req), .line_out(line_out), .line_active(line_active)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: decodes half-bit pairs and scores them
   initial begin
      bit prev_act = 1'b0, prev_line = 1'b0, first = 1'b0, in_tail = 1'b0, last_bit = 1'b0;
      int hidx = 0, last_tr = -1, tail_start = 0, nbits = 0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            prev_act = 1'b0;
            continue;
         end
         if (line_active) begin
            if (!prev_act) begin
               hidx = 0; in_tail = 1'b0; last_tr = -1;
            end else if (line_out != prev_line) begin
               last_tr = hidx;
            end
            if (!in_tail) begin
               if (hidx % 2 == 0) first = line_out;
               else if (first && line_out) begin
                  in_tail = 1'b1;
                  tail_start = hidx - 1;
               end else if (!first && !line_out) begin
                  check(1'b0, "R2 illegal low-low cell", 0, 1);
               end else begin
                  if (exp_q.size() == 0) begin
                     check(1'b0, "R3 unexpected bit", 1, 0);
                  end else begin
                     bit e;
                     e = exp_q.pop_front();
                     check(line_out == e, "R2/R3 decoded bit", line_out, e);
                     last_bit = e;
                  end
               end
            end
            hidx++;
         end else if (prev_act) begin
            nbits = tail_start / 2;
            check(hidx - tail_start == TAIL, "R5 tail length", hidx - tail_start, TAIL);
            if (last_bit)
               check(last_tr == 2 * nbits - 1, "R7 last edge mid-cell", last_tr, 2 * nbits - 1);
            else
               check(last_tr == 2 * nbits, "R6 last edge at boundary", last_tr, 2 * nbits);
            check(line_out == 1'b0, "R9 idle level after tail", line_out, 0);
         end
         prev_line = line_out;
         prev_act  = line_active;
      end
   end

   task automatic push_nib(input logic [NIB_W-1:0] n);
      for (int i = 0; i < NIB_W; i++) exp_q.push_back(n[i]);
   endtask

   // frame: nibbles sent back to back; junk and enable glitches between boundaries
   task automatic send_frame(input logic [NIB_W-1:0] nibs[], input bit glitch);
      int cnt;
      @(negedge clk);
      while (!nib_req) @(negedge clk);
      check(line_active == 1'b0, "R1 idle before start", line_active, 0);
      tx_en  = 1'b1;
      tx_nib = nibs[0];
      push_nib(nibs[0]);
      @(negedge clk);
      check(line_active == 1'b1, "R1 active next cycle", line_active, 1);
      check(line_out == ~nibs[0][0], "R1 first half-bit", line_out, ~nibs[0][0]);
      for (int k = 1; k <= nibs.size(); k++) begin
         cnt = 1;
         while (!nib_req) begin
            tx_nib = NIB_W'($urandom);
            if (glitch) tx_en = (cnt % 3 != 1);
            @(negedge clk);
            cnt++;
         end
         check(cnt == 2 * NIB_W, "R8 request spacing", cnt, 2 * NIB_W);
         if (k < nibs.size()) begin
            tx_en  = 1'b1;
            tx_nib = nibs[k];
            push_nib(nibs[k]);
         end else begin
            tx_en  = 1'b0;
            tx_nib = NIB_W'($urandom);
         end
         @(negedge clk);
      end
      while (line_active) @(negedge clk);
      check(nib_req == 1'b1, "R8 request while idle", nib_req, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(line_active == 1'b0, "R9 reset active", line_active, 0);
      check(line_out == 1'b0, "R9 reset line", line_out, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      send_frame('{4'h5}, 1'b0);                 // last bit zero (R6)
      repeat (3) @(negedge clk);
      send_frame('{4'hA}, 1'b0);                 // last bit one (R7)
      send_frame('{4'h3, 4'hC, 4'h9}, 1'b1);     // R3/R4 junk and glitches
      repeat (5) @(negedge clk);
      send_frame('{4'hF, 4'h0}, 1'b0);
      send_frame('{4'h0, 4'hF, 4'h6, 4'h1}, 1'b1);
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R3 all bits sent", exp_q.size(), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule